// File: doc/BRIEF.md
# Point-Addressed Panel Write Controller

This block sits between a processor output port and a bistable matrix display panel whose cells keep their on or off state once addressed. The processor presents a 9-bit X and a 9-bit Y coordinate together with a write or erase command line and holds them steady. The block latches the request, waits for the next boundary of the panel's sustain cycle, drives the addressing outputs for exactly one sustain period, and then raises its done status. A separate clear path, requested by two control lines asserted together, blanks the whole panel over two sustain periods.

The sustain period is a parameter counted in system clock cycles. A free-running phase timer marks the period boundaries, so every operation starts in the correct phase of the sustain waveform. The handshake is level based: after the done status returns high, the block accepts nothing new until every request line has been released, so a request that is still held never runs twice.

Top module: `pdisp_point_ctrl`

## Requirements
- R1: After reset, op_done is 1, cmd_err is 0 and drv_write, drv_erase and drv_bulk are all 0.
- R2: A request with wr_cmd=1 and er_cmd=0 asserts drv_write, with drv_x and drv_y equal to the pt_x and pt_y that were presented, and sets that point of the panel.
- R3: A request with er_cmd=1 and wr_cmd=0 asserts drv_erase with the presented coordinates and clears that point of the panel.
- R4: op_done falls in the cycle after a request is accepted, stays 0 while the operation is in progress and rises in the cycle after the drive output drops.
- R5: A point write or erase holds its drive output for exactly PERIOD_CLKS cycles, which is one sustain period.
- R6: A drive output rises only after a clock edge whose count since reset release is a multiple of PERIOD_CLKS, i.e. on a sustain-period boundary.
- R7: bulk_arm and bulk_go both at 1 assert drv_bulk for CLEAR_PERIODS x PERIOD_CLKS cycles and clear the whole panel; bulk_arm without bulk_go starts nothing and op_done stays 1.
- R8: wr_cmd and er_cmd both at 1 (without a bulk request) raise cmd_err in the next cycle, start no drive and leave op_done at 1; cmd_err returns to 0 in the cycle after all request lines are released.
- R9: A bulk request takes priority over a point request presented at the same time.
- R10: After an operation completes, no new operation starts while any request line is still held; a new one is accepted only after all lines have been low.
- R11: At most one of drv_write, drv_erase and drv_bulk is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pt_x | input | COORD_W | X coordinate of the addressed point, absolute binary |
| pt_y | input | COORD_W | Y coordinate of the addressed point, absolute binary |
| wr_cmd | input | 1 | Request to turn the addressed point on |
| er_cmd | input | 1 | Request to turn the addressed point off |
| bulk_arm | input | 1 | Whole-panel clear qualifier |
| bulk_go | input | 1 | Whole-panel clear trigger, effective only with bulk_arm |
| op_done | output | 1 | High when idle or finished, low while an operation is pending or running |
| cmd_err | output | 1 | Write and erase requested together; no operation performed |
| drv_x | output | COORD_W | Latched X coordinate to the panel address drivers |
| drv_y | output | COORD_W | Latched Y coordinate to the panel address drivers |
| drv_write | output | 1 | Write addressing pulse enable for the current sustain period |
| drv_erase | output | 1 | Erase addressing pulse enable for the current sustain period |
| drv_bulk | output | 1 | Whole-panel erase enable |

## Verification
The assertions take for granted that the processor keeps the coordinates and command lines steady from the moment it raises a request until op_done returns high, and that it releases every request line before presenting the next one. The stimulus respects this by driving each request from a task that waits for op_done, holds the lines through the whole operation plus a few extra cycles, and then drops them all. Random coordinates and command kinds are mixed with the extreme coordinates, the write-erase conflict, a lone bulk qualifier and a bulk request presented together with a point command.

// File: rtl/pdisp_pkg.sv
package pdisp_pkg;

   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_WRITE = 3'd1,
      OP_ERASE = 3'd2,
      OP_BULK  = 3'd3,
      OP_FAULT = 3'd4
   } pd_op_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WAIT  = 3'd1,
      ST_RUN   = 3'd2,
      ST_HOLD  = 3'd3,
      ST_FAULT = 3'd4
   } pd_state_e;

endpackage

// File: rtl/pdisp_phase_timer.sv
module pdisp_phase_timer #(
   parameter int PERIOD_CLKS = 1000
) (
   input  logic clk,
   input  logic rst_n,
   output logic period_tick
);
   localparam int CW = (PERIOD_CLKS > 1) ? $clog2(PERIOD_CLKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(PERIOD_CLKS - 1);

   generate
      if (PERIOD_CLKS < 2) begin : g_bad_period
         $error("pdisp_phase_timer: PERIOD_CLKS must be at least 2");
      end
   endgenerate

   logic [CW-1:0] phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase_q <= '0;
      else if (phase_q == LAST)
         phase_q <= '0;
      else
         phase_q <= phase_q + 1'b1;
   end

   assign period_tick = (phase_q == LAST);

endmodule

// File: rtl/pdisp_req_decode.sv
module pdisp_req_decode
   import pdisp_pkg::*;
(
   input  logic   wr_cmd,
   input  logic   er_cmd,
   input  logic   bulk_arm,
   input  logic   bulk_go,
   output pd_op_e req_kind,
   output logic   any_line
);
   logic bulk_req;

   assign bulk_req = bulk_arm & bulk_go;
   assign any_line = wr_cmd | er_cmd | bulk_arm | bulk_go;

   always_comb begin
      req_kind = OP_NONE;
      if (bulk_req)
         req_kind = OP_BULK;
      else if (wr_cmd && er_cmd)
         req_kind = OP_FAULT;
      else if (wr_cmd)
         req_kind = OP_WRITE;
      else if (er_cmd)
         req_kind = OP_ERASE;
   end

endmodule

// File: rtl/pdisp_op_seq.sv
module pdisp_op_seq
   import pdisp_pkg::*;
#(
   parameter int COORD_W       = 9,
   parameter int CLEAR_PERIODS = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               period_tick,
   input  pd_op_e             req_kind,
   input  logic               any_line,
   input  logic [COORD_W-1:0] pt_x,
   input  logic [COORD_W-1:0] pt_y,
   output logic               op_done,
   output logic               cmd_err,
   output logic [COORD_W-1:0] drv_x,
   output logic [COORD_W-1:0] drv_y,
   output logic               drv_write,
   output logic               drv_erase,
   output logic               drv_bulk
);
   generate
      if (CLEAR_PERIODS < 1) begin : g_bad_clear
         $error("pdisp_op_seq: CLEAR_PERIODS must be at least 1");
      end
   endgenerate

   pd_state_e          state_q;
   pd_op_e             op_q;
   logic [COORD_W-1:0] x_q;
   logic [COORD_W-1:0] y_q;
   logic               last_period;
   logic               running;

   assign running = (state_q == ST_RUN);

   generate
      if (CLEAR_PERIODS > 1) begin : g_multi
         localparam int PW = $clog2(CLEAR_PERIODS);
         localparam logic [PW-1:0] PLAST = PW'(CLEAR_PERIODS - 1);
         logic [PW-1:0] per_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               per_q <= '0;
            else if (!running)
               per_q <= '0;
            else if (period_tick)
               per_q <= per_q + 1'b1;
         end

         assign last_period = (op_q != OP_BULK) || (per_q == PLAST);
      end else begin : g_single
         assign last_period = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_NONE;
         x_q     <= '0;
         y_q     <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_kind == OP_FAULT) begin
                  state_q <= ST_FAULT;
               end else if (req_kind != OP_NONE) begin
                  state_q <= ST_WAIT;
                  op_q    <= req_kind;
                  x_q     <= pt_x;
                  y_q     <= pt_y;
               end
            end
            ST_WAIT:  if (period_tick) state_q <= ST_RUN;
            ST_RUN:   if (period_tick && last_period) state_q <= ST_HOLD;
            ST_HOLD:  if (!any_line) state_q <= ST_IDLE;
            ST_FAULT: if (!any_line) state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign op_done   = (state_q == ST_IDLE) || (state_q == ST_HOLD) || (state_q == ST_FAULT);
   assign cmd_err   = (state_q == ST_FAULT);
   assign drv_x     = x_q;
   assign drv_y     = y_q;
   assign drv_write = running && (op_q == OP_WRITE);
   assign drv_erase = running && (op_q == OP_ERASE);
   assign drv_bulk  = running && (op_q == OP_BULK);

endmodule

// File: rtl/pdisp_point_ctrl.sv
module pdisp_point_ctrl
   import pdisp_pkg::*;
#(
   parameter int COORD_W       = 9,
   parameter int PERIOD_CLKS   = 1000,
   parameter int CLEAR_PERIODS = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [COORD_W-1:0] pt_x,
   input  logic [COORD_W-1:0] pt_y,
   input  logic               wr_cmd,
   input  logic               er_cmd,
   input  logic               bulk_arm,
   input  logic               bulk_go,
   output logic               op_done,
   output logic               cmd_err,
   output logic [COORD_W-1:0] drv_x,
   output logic [COORD_W-1:0] drv_y,
   output logic               drv_write,
   output logic               drv_erase,
   output logic               drv_bulk
);
   generate
      if (COORD_W < 1) begin : g_bad_coord
         $error("pdisp_point_ctrl: COORD_W must be positive");
      end
   endgenerate

   logic   period_tick;
   pd_op_e req_kind;
   logic   any_line;

   pdisp_phase_timer #(.PERIOD_CLKS(PERIOD_CLKS)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .period_tick (period_tick)
   );

   pdisp_req_decode u_dec (
      .wr_cmd   (wr_cmd),
      .er_cmd   (er_cmd),
      .bulk_arm (bulk_arm),
      .bulk_go  (bulk_go),
      .req_kind (req_kind),
      .any_line (any_line)
   );

   pdisp_op_seq #(
      .COORD_W       (COORD_W),
      .CLEAR_PERIODS (CLEAR_PERIODS)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .period_tick (period_tick),
      .req_kind    (req_kind),
      .any_line    (any_line),
      .pt_x        (pt_x),
      .pt_y        (pt_y),
      .op_done     (op_done),
      .cmd_err     (cmd_err),
      .drv_x       (drv_x),
      .drv_y       (drv_y),
      .drv_write   (drv_write),
      .drv_erase   (drv_erase),
      .drv_bulk    (drv_bulk)
   );

endmodule

// File: rtl/pdisp_point_ctrl_chk.sv
module pdisp_point_ctrl_chk #(
   parameter int COORD_W = 9
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_cmd,
   input logic               er_cmd,
   input logic               bulk_arm,
   input logic               bulk_go,
   input logic               op_done,
   input logic               cmd_err,
   input logic [COORD_W-1:0] drv_x,
   input logic [COORD_W-1:0] drv_y,
   input logic               drv_write,
   input logic               drv_erase,
   input logic               drv_bulk
);
   logic drv_any;
   assign drv_any = drv_write | drv_erase | drv_bulk;

   a_r11_one_drive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({drv_write, drv_erase, drv_bulk}));

   a_r4_busy_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
      drv_any |-> !op_done);

   a_r8_fault_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |-> (!drv_any && op_done));

   a_r2_coords_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_any && $past(drv_any)) |-> ($stable(drv_x) && $stable(drv_y)));

   a_r10_accept_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(op_done) |-> $past(wr_cmd || er_cmd || (bulk_arm && bulk_go)));

endmodule

bind pdisp_point_ctrl pdisp_point_ctrl_chk #(.COORD_W(COORD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_cmd    (wr_cmd),
   .er_cmd    (er_cmd),
   .bulk_arm  (bulk_arm),
   .bulk_go   (bulk_go),
   .op_done   (op_done),
   .cmd_err   (cmd_err),
   .drv_x     (drv_x),
   .drv_y     (drv_y),
   .drv_write (drv_write),
   .drv_erase (drv_erase),
   .drv_bulk  (drv_bulk)
);

// File: tb/pdisp_point_ctrl_tb_top.sv
module pdisp_point_ctrl_tb_top;
   localparam int CW = 9;
   localparam int P  = 8;
   localparam int NC = 2;
   localparam int LIMIT = 200;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] pt_x = '0, pt_y = '0;
   logic          wr_cmd = 0, er_cmd = 0, bulk_arm = 0, bulk_go = 0;
   logic          op_done, cmd_err, drv_write, drv_erase, drv_bulk;
   logic [CW-1:0] drv_x, drv_y;

   int n_tests = 0;
   int n_fail  = 0;
   int edge_cnt = 0;
   int cyc = 0;

   bit panel [int];
   bit expect_px [int];
   logic prev_w = 0, prev_e = 0, prev_b = 0;

   always #10 clk = ~clk;

   pdisp_point_ctrl #(.COORD_W(CW), .PERIOD_CLKS(P), .CLEAR_PERIODS(NC)) dut_i (
      .clk(clk), .rst_n(rst_n), .pt_x(pt_x), .pt_y(pt_y),
      .wr_cmd(wr_cmd), .er_cmd(er_cmd), .bulk_arm(bulk_arm), .bulk_go(bulk_go),
      .op_done(op_done), .cmd_err(cmd_err), .drv_x(drv_x), .drv_y(drv_y),
      .drv_write(drv_write), .drv_erase(drv_erase), .drv_bulk(drv_bulk)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n) edge_cnt <= 0;
      else        edge_cnt <= edge_cnt + 1;
   end

   // panel model driven only by the drive outputs
   always @(negedge clk) begin
      if (drv_write && !prev_w) panel[{drv_x, drv_y}] = 1'b1;
      if (drv_erase && !prev_e) panel[{drv_x, drv_y}] = 1'b0;
      if (drv_bulk  && !prev_b) panel.delete();
      prev_w = drv_write; prev_e = drv_erase; prev_b = drv_bulk;
   end

   function automatic int key_of(input logic [CW-1:0] x, input logic [CW-1:0] y);
      return int'({x, y});
   endfunction

   function automatic int drive_len(input int kind);
      return (kind == 3) ? NC * P : P;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // kind: 1 write, 2 erase, 3 bulk, 4 bulk plus write
   task automatic run_op(input int kind, input logic [CW-1:0] x, input logic [CW-1:0] y);
      int dur = 0, start_e = -1, n = 0, eff;
      bit seen_drv = 0, coord_ok = 1, wrong_line = 0;
      while (!op_done) @(negedge clk);
      pt_x = x; pt_y = y;
      wr_cmd = (kind == 1) || (kind == 4);
      er_cmd = (kind == 2);
      bulk_arm = (kind >= 3); bulk_go = (kind >= 3);
      eff = (kind == 4) ? 3 : kind;
      @(negedge clk);
      check(op_done == 1'b0, "R4 done falls after accept", op_done, 0);
      while (!op_done && n < LIMIT) begin
         if (drv_write || drv_erase || drv_bulk) begin
            if (!seen_drv) start_e = edge_cnt;
            seen_drv = 1; dur++;
            if (eff != 3 && (drv_x != x || drv_y != y)) coord_ok = 0;
            if ((eff == 1 && !drv_write) || (eff == 2 && !drv_erase) || (eff == 3 && !drv_bulk))
               wrong_line = 1;
         end else if (seen_drv) begin
            check(0, "R4 done rises after drive drops", 0, 1);
         end
         @(negedge clk); n++;
      end
      check(n < LIMIT, "R4 operation completes", n, LIMIT);
      check(dur == drive_len(eff), (eff == 3) ? "R7 bulk length" : "R5 point length",
            dur, drive_len(eff));
      check(start_e >= 0 && (start_e % P) == 0, "R6 start on boundary", start_e, 0);
      check(!wrong_line, (kind == 4) ? "R9 bulk wins" : (kind == 2) ? "R3 erase line" : "R2 write line",
            wrong_line, 0);
      check(coord_ok, (kind == 2) ? "R3 coords" : "R2 coords", coord_ok, 1);
      for (int i = 0; i < 2 * P; i++) begin
         @(negedge clk);
         check(op_done && !drv_write && !drv_erase && !drv_bulk, "R10 no retrigger while held",
               op_done, 1);
      end
      wr_cmd = 0; er_cmd = 0; bulk_arm = 0; bulk_go = 0;
      @(negedge clk);
      if (eff == 3) expect_px.delete();
      else expect_px[key_of(x, y)] = (eff == 1);
   endtask

   initial begin
      int kind;
      logic [CW-1:0] rx, ry;
      bit match;
      void'($urandom(32'h5EED_0A11));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(op_done == 1 && cmd_err == 0 && !drv_write && !drv_erase && !drv_bulk,
            "R1 reset state", {op_done, cmd_err, drv_write, drv_erase, drv_bulk}, 5'b10000);

      // directed corners
      run_op(1, 9'd0, 9'd0);
      run_op(1, 9'd511, 9'd511);
      run_op(1, 9'd511, 9'd0);
      run_op(2, 9'd511, 9'd511);

      // write and erase together: fault, no drive
      wr_cmd = 1; er_cmd = 1; pt_x = 9'd7; pt_y = 9'd9;
      @(negedge clk);
      check(cmd_err == 1, "R8 fault flagged", cmd_err, 1);
      for (int i = 0; i < 2 * P; i++) begin
         @(negedge clk);
         check(op_done && !drv_write && !drv_erase && !drv_bulk, "R8 fault no operation", op_done, 1);
      end
      wr_cmd = 0; er_cmd = 0;
      @(negedge clk);
      check(cmd_err == 0, "R8 fault clears on release", cmd_err, 0);

      // lone qualifier does nothing
      bulk_arm = 1;
      for (int i = 0; i < 2 * P; i++) begin
         @(negedge clk);
         check(op_done && !drv_bulk, "R7 arm alone ignored", op_done, 1);
      end
      bulk_arm = 0;
      @(negedge clk);

      run_op(4, 9'd3, 9'd4);
      check(!panel.exists(key_of(9'd0, 9'd0)) || panel[key_of(9'd0, 9'd0)] == 0,
            "R7 bulk cleared panel", 1, 0);
      check(!panel.exists(key_of(9'd3, 9'd4)) || panel[key_of(9'd3, 9'd4)] == 0,
            "R9 point not written with bulk", 1, 0);

      for (int t = 0; t < 40; t++) begin
         kind = ($urandom % 10 < 6) ? 1 : ($urandom % 10 < 8) ? 2 : 3;
         rx = CW'($urandom % 16); ry = CW'($urandom % 16);
         run_op(kind, rx, ry);
      end

      match = 1;
      foreach (expect_px[k]) begin
         if ((panel.exists(k) ? panel[k] : 1'b0) != expect_px[k]) match = 0;
      end
      foreach (panel[k]) begin
         if ((expect_px.exists(k) ? expect_px[k] : 1'b0) != panel[k]) match = 0;
      end
      check(match, "R2 R3 panel contents", match, 1);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      wait (cyc > 150000);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule